// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is the storage end of an on-chip trace path. Trace words arrive on a valid/ready stream and are written into a circular RAM while capture is on. Software sets up and drains the buffer through a small register port with APB-style timing. That port exposes the buffer depth, both RAM pointers, and two data windows that advance their pointers on every access. It also holds a post-trigger word count, a capture enable and a formatter control word. The formatter control word can request a flush, stop capture when a flush ends, and stop capture a set number of words after a trigger.

Back-pressure rules for the trace stream are simple. A word is taken on a rising clock edge where both `trc_valid` and `trc_ready` are high. `trc_ready` falls in four cases:
- capture is off;
- a flush is in progress;
- the post-trigger count has run out;
- the register port performs any write access in that cycle.

The source must hold its word while `trc_ready` is low. A flush pads the RAM with zero words until the write pointer sits on a 4-word frame boundary, so that a drained capture always ends on a whole frame.

Top module: `trace_capture_buffer`

## Requirements
- R1: A read of offset 0x004 returns the RAM depth in words (the DEPTH parameter).
- R2: A write to offset 0x024 stores the word at the write-pointer address, then advances the write pointer by one, modulo DEPTH.
- R3: A read of offset 0x010 returns the word at the read-pointer address, then advances the read pointer by one, modulo DEPTH.
- R4: Offsets 0x014 (read pointer) and 0x018 (write pointer) are readable and writable. Each holds log2(DEPTH) bits in bits [AW-1:0].
- R5: Status offset 0x00C bit 0 (RAM full) is set when the write pointer wraps from DEPTH-1 to 0, for any reason. It stays set until software writes offset 0x018, which clears it.
- R6: Control offset 0x020 bit 0 turns capture on and off. While it is 0, `trc_ready` is low and no trace word is stored. Each accepted trace word is stored at the write pointer, which then advances by one.
- R7: With formatter control bit 13 set, a `trigger` pulse taken while capture is on works as follows. The word accepted in the trigger cycle is stored. Exactly the count held at offset 0x01C of further words are then stored, after which control bit 0 reads 0. A second trigger during the count has no effect. With bit 13 clear, a trigger changes nothing.
- R8: Writing formatter control (offset 0x304) with bit 6 set starts a flush, and bit 6 reads 1 until the flush ends. While capture is on, the flush writes zero words until the write pointer is a multiple of 4. `trc_ready` stays low for the whole flush.
- R9: If formatter control bit 12 is set when a flush ends, capture is turned off (control bit 0 reads 0).
- R10: Formatter status offset 0x300 has two bits. Bit 1 reads 1 when capture is off and no flush is pending. Bit 0 reads 1 while a flush is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| apb_sel | input | 1 | Register port select |
| apb_enable | input | 1 | Access phase of a register transfer |
| apb_write | input | 1 | 1 = write, 0 = read |
| apb_addr | input | ADDR_W | Byte offset of the register |
| apb_wdata | input | DW | Write data |
| apb_rdata | output | DW | Read data, valid while selected for a read |
| trc_valid | input | 1 | Trace word offered |
| trc_data | input | DW | Trace word |
| trc_ready | output | 1 | Buffer will take the offered word |
| trigger | input | 1 | Single-cycle trigger event |

## Verification
The assertions assume several things about the inputs:
- Register transfers follow the setup-then-access order.
- `trigger` is a one-cycle pulse.
- The trace source never relies on a word being taken while `trc_ready` is low.

Pointer-step and flush-alignment checks also assume the register port does not write the write pointer in the same cycle a flush completes. The stimulus keeps to these rules in three ways. Every register access is a three-phase task that drives only on falling edges. Trace words are offered only with valid and sampled readiness. Flushes are started from idle register traffic and left to finish before the pointer is touched again.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

  // Register byte offsets
  localparam int OFF_DEPTH  = 'h004;
  localparam int OFF_STAT   = 'h00C;
  localparam int OFF_RDATA  = 'h010;
  localparam int OFF_RPTR   = 'h014;
  localparam int OFF_WPTR   = 'h018;
  localparam int OFF_TRGCNT = 'h01C;
  localparam int OFF_CTRL   = 'h020;
  localparam int OFF_WDATA  = 'h024;
  localparam int OFF_FSTAT  = 'h300;
  localparam int OFF_FCTRL  = 'h304;

  // Formatter control bit positions
  localparam int FC_FMT_EN    = 0;
  localparam int FC_FLUSH     = 6;
  localparam int FC_STOP_FL   = 12;
  localparam int FC_STOP_TRIG = 13;

  typedef struct packed {
    logic fmt_en;
    logic stop_flush;
    logic stop_trig;
  } fmt_cfg_t;

  // Source of the single RAM write port in a given cycle
  typedef enum logic [1:0] {
    WS_NONE  = 2'd0,
    WS_APB   = 2'd1,
    WS_PAD   = 2'd2,
    WS_TRACE = 2'd3
  } wsrc_e;

endpackage

// File: rtl/tcb_ptr.sv
module tcb_ptr #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr,
  output logic          wrap
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam bit            POW2 = ((1 << AW) == DEPTH);

  logic [AW-1:0] nxt;

  generate
    if (POW2) begin : g_pow2
      assign nxt = ptr + 1'b1;
    end else begin : g_cmp
      assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= nxt;
  end

  assign wrap = inc && !load && (ptr == LAST);

endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          ctrl_en_in,
  input  logic          fmt_wr,
  input  fmt_cfg_t      fmt_in,
  input  logic          flush_req,
  input  logic [TW-1:0] trig_cnt,
  input  logic          trigger,
  input  logic          trc_acc,
  input  logic          aligned,
  input  logic          apb_blk,
  output logic          cap_en,
  output logic          flush_busy,
  output logic          counting,
  output logic [TW-1:0] remain,
  output logic          stop_hit,
  output logic          pad_we,
  output fmt_cfg_t      cfg
);

  logic flush_done;

  always_comb begin
    stop_hit   = counting && (remain == '0);
    pad_we     = flush_busy && cap_en && !aligned && !apb_blk;
    flush_done = flush_busy && !apb_blk && (!cap_en || aligned);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en     <= 1'b0;
      flush_busy <= 1'b0;
      counting   <= 1'b0;
      remain     <= '0;
      cfg        <= '0;
    end else begin
      // capture enable: software write wins, then the two stop causes
      if (ctrl_wr)
        cap_en <= ctrl_en_in;
      else if (stop_hit || (flush_done && cfg.stop_flush))
        cap_en <= 1'b0;

      // post-trigger down-counter
      if (ctrl_wr || stop_hit) begin
        counting <= 1'b0;
      end else if (!counting && cap_en && trigger && cfg.stop_trig) begin
        counting <= 1'b1;
        remain   <= trig_cnt;
      end else if (counting && trc_acc) begin
        remain <= remain - 1'b1;
      end

      if (fmt_wr) cfg <= fmt_in;

      if (fmt_wr && flush_req) flush_busy <= 1'b1;
      else if (flush_done)     flush_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DW     = 32,
  parameter int ADDR_W = 12,
  parameter int TW     = 16,
  parameter int FRAME  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apb_sel,
  input  logic              apb_enable,
  input  logic              apb_write,
  input  logic [ADDR_W-1:0] apb_addr,
  input  logic [DW-1:0]     apb_wdata,
  output logic [DW-1:0]     apb_rdata,
  input  logic              trc_valid,
  input  logic [DW-1:0]     trc_data,
  output logic              trc_ready,
  input  logic              trigger
);

  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(FRAME);

  // register port decode
  logic acc, wr_acc, rd_acc;
  logic wdat_wr, rdat_rd, wptr_ld, rptr_ld, trg_wr, ctrl_wr, fmt_wr;

  always_comb begin
    acc     = apb_sel && apb_enable;
    wr_acc  = acc && apb_write;
    rd_acc  = acc && !apb_write;
    wdat_wr = wr_acc && (apb_addr == ADDR_W'(OFF_WDATA));
    rdat_rd = rd_acc && (apb_addr == ADDR_W'(OFF_RDATA));
    wptr_ld = wr_acc && (apb_addr == ADDR_W'(OFF_WPTR));
    rptr_ld = wr_acc && (apb_addr == ADDR_W'(OFF_RPTR));
    trg_wr  = wr_acc && (apb_addr == ADDR_W'(OFF_TRGCNT));
    ctrl_wr = wr_acc && (apb_addr == ADDR_W'(OFF_CTRL));
    fmt_wr  = wr_acc && (apb_addr == ADDR_W'(OFF_FCTRL));
  end

  // state
  logic [AW-1:0] wptr, rptr;
  logic          wwrap, rwrap_unused;
  logic          ram_full;
  logic [TW-1:0] trig_cnt_q;
  logic          cap_en, flush_busy, counting, stop_hit, pad_we;
  logic [TW-1:0] remain;
  fmt_cfg_t      cfg, fmt_in;
  logic          aligned, apb_blk, trc_acc;
  wsrc_e         wsrc;
  logic          wptr_inc;
  logic [DW-1:0] ram_wdata, ram_rdata;

  assign aligned = (wptr[FW-1:0] == '0);
  assign apb_blk = wdat_wr || wptr_ld;

  assign trc_ready = cap_en && !flush_busy && !stop_hit && !wr_acc;
  assign trc_acc   = trc_valid && trc_ready;

  always_comb begin
    fmt_in.fmt_en     = apb_wdata[FC_FMT_EN];
    fmt_in.stop_flush = apb_wdata[FC_STOP_FL];
    fmt_in.stop_trig  = apb_wdata[FC_STOP_TRIG];
  end

  // single RAM write port: register window, then flush pad, then trace
  always_comb begin
    if (wdat_wr)     wsrc = WS_APB;
    else if (pad_we) wsrc = WS_PAD;
    else if (trc_acc) wsrc = WS_TRACE;
    else             wsrc = WS_NONE;
    case (wsrc)
      WS_APB:   ram_wdata = apb_wdata;
      WS_TRACE: ram_wdata = trc_data;
      default:  ram_wdata = '0;
    endcase
    wptr_inc = (wsrc != WS_NONE);
  end

  tcb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wptr_ld),
    .load_val (apb_wdata[AW-1:0]),
    .inc      (wptr_inc),
    .ptr      (wptr),
    .wrap     (wwrap)
  );

  tcb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rptr_ld),
    .load_val (apb_wdata[AW-1:0]),
    .inc      (rdat_rd),
    .ptr      (rptr),
    .wrap     (rwrap_unused)
  );

  tcb_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wptr_inc),
    .waddr (wptr),
    .wdata (ram_wdata),
    .raddr (rptr),
    .rdata (ram_rdata)
  );

  tcb_ctrl #(.TW(TW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_en_in (apb_wdata[0]),
    .fmt_wr     (fmt_wr),
    .fmt_in     (fmt_in),
    .flush_req  (apb_wdata[FC_FLUSH]),
    .trig_cnt   (trig_cnt_q),
    .trigger    (trigger),
    .trc_acc    (trc_acc),
    .aligned    (aligned),
    .apb_blk    (apb_blk),
    .cap_en     (cap_en),
    .flush_busy (flush_busy),
    .counting   (counting),
    .remain     (remain),
    .stop_hit   (stop_hit),
    .pad_we     (pad_we),
    .cfg        (cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_full   <= 1'b0;
      trig_cnt_q <= '0;
    end else begin
      if (wptr_ld)    ram_full <= 1'b0;
      else if (wwrap) ram_full <= 1'b1;
      if (trg_wr) trig_cnt_q <= apb_wdata[TW-1:0];
    end
  end

  // read mux
  always_comb begin
    apb_rdata = '0;
    if (apb_sel && !apb_write) begin
      case (int'(apb_addr))
        OFF_DEPTH:  apb_rdata = DW'(DEPTH);
        OFF_STAT:   apb_rdata[0] = ram_full;
        OFF_RDATA:  apb_rdata = ram_rdata;
        OFF_RPTR:   apb_rdata[AW-1:0] = rptr;
        OFF_WPTR:   apb_rdata[AW-1:0] = wptr;
        OFF_TRGCNT: apb_rdata[TW-1:0] = trig_cnt_q;
        OFF_CTRL:   apb_rdata[0] = cap_en;
        OFF_FSTAT: begin
          apb_rdata[1] = !cap_en && !flush_busy;
          apb_rdata[0] = flush_busy;
        end
        OFF_FCTRL: begin
          apb_rdata[FC_FMT_EN]    = cfg.fmt_en;
          apb_rdata[FC_FLUSH]     = flush_busy;
          apb_rdata[FC_STOP_FL]   = cfg.stop_flush;
          apb_rdata[FC_STOP_TRIG] = cfg.stop_trig;
        end
        default: apb_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tcb_checker.sv
module tcb_checker
  import tcb_pkg::*;
#(
  parameter int AW     = 8,
  parameter int TW     = 16,
  parameter int FW     = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              apb_sel,
  input logic              apb_enable,
  input logic              apb_write,
  input logic [ADDR_W-1:0] apb_addr,
  input logic              trc_valid,
  input logic              trc_ready,
  input logic              cap_en,
  input logic              flush_busy,
  input logic              counting,
  input logic [TW-1:0]     remain,
  input logic [AW-1:0]     wptr,
  input logic [AW-1:0]     rptr,
  input logic              ram_full
);

  logic rd_data_acc, wptr_wr;
  assign rd_data_acc = apb_sel && apb_enable && !apb_write && (apb_addr == ADDR_W'(OFF_RDATA));
  assign wptr_wr     = apb_sel && apb_enable && apb_write && (apb_addr == ADDR_W'(OFF_WPTR));

  AST_READY_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !trc_ready); // R6
  AST_TRACE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && trc_ready) |=> (wptr == AW'($past(wptr) + 1'b1))); // R6
  AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_acc |=> (rptr == AW'($past(rptr) + 1'b1))); // R3
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_full && !wptr_wr) |=> ram_full); // R5
  AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_wr |=> !ram_full); // R5
  AST_COUNT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && (remain == '0)) |-> !trc_ready); // R7
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !trc_ready); // R8
  AST_FLUSH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flush_busy) && $past(cap_en)) |-> (wptr[FW-1:0] == '0)); // R8

endmodule

bind trace_capture_buffer tcb_checker #(
  .AW(AW), .TW(TW), .FW(FW), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .apb_sel    (apb_sel),
  .apb_enable (apb_enable),
  .apb_write  (apb_write),
  .apb_addr   (apb_addr),
  .trc_valid  (trc_valid),
  .trc_ready  (trc_ready),
  .cap_en     (cap_en),
  .flush_busy (flush_busy),
  .counting   (counting),
  .remain     (remain),
  .wptr       (wptr),
  .rptr       (rptr),
  .ram_full   (ram_full)
);

// File: tb/trace_capture_buffer_bench.sv
`timescale 1ns/1ps
module trace_capture_buffer_bench;

  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int AW    = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          apb_sel = 1'b0, apb_enable = 1'b0, apb_write = 1'b0;
  logic [AW-1:0] apb_addr = '0;
  logic [DW-1:0] apb_wdata = '0;
  logic [DW-1:0] apb_rdata;
  logic          trc_valid = 1'b0;
  logic [DW-1:0] trc_data = '0;
  logic          trc_ready;
  logic          trigger = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trace_capture_buffer #(.DEPTH(DEPTH), .DW(DW), .ADDR_W(AW), .TW(16), .FRAME(4))
  u_trace_capture_buffer (
    .clk(clk), .rst_n(rst_n), .apb_sel(apb_sel), .apb_enable(apb_enable),
    .apb_write(apb_write), .apb_addr(apb_addr), .apb_wdata(apb_wdata),
    .apb_rdata(apb_rdata), .trc_valid(trc_valid), .trc_data(trc_data),
    .trc_ready(trc_ready), .trigger(trigger)
  );

  function automatic logic [31:0] dfun(input int i);
    return 32'hC0DE0000 + 32'(i) * 32'h00010003;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    apb_sel = 1; apb_write = 1; apb_enable = 0; apb_addr = AW'(a); apb_wdata = d;
    @(negedge clk);
    apb_enable = 1;
    @(negedge clk);
    apb_sel = 0; apb_enable = 0; apb_write = 0;
  endtask

  task automatic apb_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    apb_sel = 1; apb_write = 0; apb_enable = 0; apb_addr = AW'(a);
    @(negedge clk);
    apb_enable = 1;
    #1 d = apb_rdata;
    @(negedge clk);
    apb_sel = 0; apb_enable = 0;
  endtask

  // offer n words back to back; returns how many were taken
  task automatic stream(input int n, input int t1, input int t2, output int taken);
    taken = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      trc_valid = 1; trc_data = dfun(c);
      trigger = (c == t1) || (c == t2);
      #1 if (trc_ready) taken++;
    end
    @(negedge clk);
    trc_valid = 0; trigger = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int taken;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    apb_rd('h004, rd); check("R1 depth", rd, DEPTH);
    apb_rd('h00C, rd); check("R5 status at reset", rd, 0);
    apb_rd('h020, rd); check("R6 ctrl at reset", rd, 0);
    apb_rd('h300, rd); check("R10 fstat at reset", rd, 32'h2);
    #1 check("R6 ready low at reset", 32'(trc_ready), 0);

    // fill through the write window
    apb_wr('h018, 0);
    for (int i = 0; i < DEPTH - 1; i++) apb_wr('h024, dfun(100 + i));
    apb_rd('h00C, rd); check("R5 not full before wrap", rd, 0);
    apb_wr('h024, dfun(100 + DEPTH - 1));
    apb_rd('h00C, rd); check("R5 full after wrap", rd, 1);
    apb_rd('h018, rd); check("R2 wptr wrapped", rd, 0);
    apb_wr('h014, 0);
    for (int i = 0; i < DEPTH + 3; i++) begin
      apb_rd('h010, rd); check("R3 read window", rd, dfun(100 + (i % DEPTH)));
    end
    apb_rd('h014, rd); check("R4 rptr after reads", rd, 3);
    apb_wr('h018, 5);
    apb_rd('h00C, rd); check("R5 full cleared", rd, 0);
    apb_rd('h018, rd); check("R4 wptr readback", rd, 5);

    // every start position
    for (int s = 0; s < DEPTH; s++) begin
      apb_wr('h018, s);
      apb_wr('h024, dfun(200 + s));
      apb_rd('h018, rd); check("R2 wptr step", rd, (s + 1) % DEPTH);
      apb_rd('h00C, rd); check("R5 wrap flag", rd, (s == DEPTH - 1) ? 1 : 0);
      apb_wr('h014, s);
      apb_rd('h010, rd); check("R3 word at rptr", rd, dfun(200 + s));
      apb_rd('h014, rd); check("R4 rptr step", rd, (s + 1) % DEPTH);
    end

    // capture
    apb_wr('h018, 0);
    apb_wr('h020, 1);
    stream(10, -1, -1, taken); check("R6 words taken", taken, 10);
    apb_rd('h018, rd); check("R6 wptr after capture", rd, 10);
    apb_wr('h014, 0);
    for (int i = 0; i < 10; i++) begin
      apb_rd('h010, rd); check("R6 captured word", rd, dfun(i));
    end
    apb_wr('h020, 0);
    stream(3, -1, -1, taken); check("R6 nothing taken when off", taken, 0);
    apb_rd('h018, rd); check("R6 wptr unchanged when off", rd, 10);

    // stop on trigger, counts 0..6, second trigger ignored
    for (int n = 0; n <= 6; n++) begin
      apb_wr('h018, 0);
      apb_wr('h304, 32'h2000);
      apb_wr('h01C, n);
      apb_wr('h020, 1);
      stream(12, 3, 5, taken); check("R7 post-trigger words", taken, 4 + n);
      apb_rd('h018, rd); check("R7 wptr", rd, 4 + n);
      apb_rd('h020, rd); check("R7 capture stopped", rd, 0);
      apb_wr('h014, 0);
      for (int i = 0; i < 4 + n; i++) begin
        apb_rd('h010, rd); check("R7 stored word", rd, dfun(i));
      end
    end
    apb_wr('h304, 0);
    apb_wr('h018, 0);
    apb_wr('h020, 1);
    stream(20, 3, 5, taken); check("R7 trigger ignored without stop bit", taken, 20);
    apb_rd('h018, rd); check("R5 wptr after capture wrap", rd, 4);
    apb_rd('h00C, rd); check("R5 full from capture", rd, 1);
    apb_rd('h020, rd); check("R7 capture still on", rd, 1);
    apb_rd('h300, rd); check("R10 fstat running", rd, 0);

    // flush padding sweep
    for (int k = 1; k <= 7; k++) begin
      int expw;
      expw = ((k + 3) / 4) * 4;
      apb_wr('h018, 0);
      stream(k, -1, -1, taken);
      apb_wr('h304, 32'h0040);
      if (k == 5) begin
        apb_rd('h304, rd); check("R8 flush bit busy", rd, 32'h40);
        #1 check("R8 ready low in flush", 32'(trc_ready), 0);
      end
      repeat (8) @(negedge clk);
      apb_rd('h304, rd); check("R8 flush bit cleared", rd, 0);
      apb_rd('h018, rd); check("R8 aligned wptr", rd, expw);
      if (expw != k) begin
        apb_wr('h014, expw - 1);
        apb_rd('h010, rd); check("R8 pad word zero", rd, 0);
      end
    end

    // stop on flush
    apb_wr('h018, 0);
    stream(2, -1, -1, taken);
    apb_wr('h304, 32'h1040);
    repeat (8) @(negedge clk);
    apb_rd('h020, rd); check("R9 capture off after flush", rd, 0);
    apb_rd('h018, rd); check("R9 wptr aligned", rd, 4);
    apb_rd('h300, rd); check("R10 fstat stopped", rd, 32'h2);

    done = 1;
    summary();
    $finish;
  end

endmodule